// File: doc/BRIEF.md
# Asynchronous Bus Termination Classifier

This block sits beside an asynchronous bus master and decides how each bus cycle ends. It watches three active-low termination inputs: a two-bit data-size acknowledge, a bus-error strobe and a halt strobe. Each input passes through a two-flop synchronizer. A bus-state counter starts at state 0 when a cycle begins and advances by one state per clock. The classifier samples only on even states. The first sample that shows an acknowledge or a bus error is called sample n. A second sample is taken two states later, at n+2.

The pair of samples picks one of four results, and each result is given as a single-cycle pulse. A normal end gives `done`. An end followed by a stall gives `halt_done`. An error gives `bus_error`, and `berr_deferred` can mark that error as one that may be taken later. A request to rerun the cycle gives `retry`. After `halt_done` or `retry`, the `stall` level stays high until halt is released. An input pattern that fits none of the legal orderings is reported as a bus error, so a cycle never hangs.

The state machine has four states:
- `ST_IDLE` waits for `cycle_start`.
- `ST_AWAIT_N` takes a sample on each even state until an acknowledge or a bus error shows up.
- `ST_AWAIT_N2` takes the second sample on the next even state and classifies the pair.
- `ST_STALL` holds until halt is negated.

The transitions are:
- start: `ST_IDLE` to `ST_AWAIT_N`.
- wait: `ST_AWAIT_N` to itself.
- first-sample: `ST_AWAIT_N` to `ST_AWAIT_N2`.
- finish: `ST_AWAIT_N2` to `ST_IDLE`.
- hold: `ST_AWAIT_N2` to `ST_STALL`.
- release: `ST_STALL` to `ST_IDLE`.

Top module: `bus_term_classifier`

## Requirements
- R1: After reset, `done`, `halt_done`, `bus_error`, `berr_deferred`, `retry` and `stall` are all 0.
- R2: Every termination input is active low and passes through two synchronizer flops. The acknowledge counts as asserted when either bit of `ack_n` is 0. On an even state with neither acknowledge nor bus error asserted, the block inserts wait states and samples again two states later. This holds even when halt alone is asserted. With inputs already settled when the cycle starts, the result pulse appears 3 clocks after the `cycle_start` edge. Each wait round adds 2 clocks.
- R3: If n shows acknowledge with bus error and halt negated, and n+2 shows acknowledge with bus error negated (halt ignored), the block pulses `done`.
- R4: If n shows acknowledge and halt with bus error negated, and n+2 shows acknowledge and halt with bus error negated, the block pulses `halt_done`.
- R5: If n shows bus error with halt negated (acknowledge ignored), and n+2 shows bus error with halt negated, the block pulses `bus_error`.
- R6: If n shows acknowledge only, and n+2 shows bus error with halt negated, the block pulses `bus_error`. This is the late-error case.
- R7: If n shows bus error and halt (acknowledge ignored), and n+2 shows both still asserted, the block pulses `retry`.
- R8: If n shows acknowledge only, and n+2 shows bus error and halt, the block pulses `retry`. This is the late-retry case.
- R9: `stall` rises together with a `halt_done` or `retry` pulse. It stays high until the synchronized halt is negated and then falls within 3 clocks. `stall` is never high with any other result.
- R10: Any sample pair that matches none of R3 to R8 pulses `bus_error`.
- R11: `berr_deferred` pulses together with `bus_error` when `defer_en` is 1, and stays 0 otherwise.
- R12: The result outputs are one-hot and each is a one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | Begins a bus cycle when the block is idle |
| ack_n | input | ACK_W | Data-size acknowledge, active low |
| berr_n | input | 1 | Bus-error strobe, active low |
| halt_n | input | 1 | Halt strobe, active low |
| defer_en | input | 1 | Marks a bus-error result as deferrable |
| done | output | 1 | Normal termination pulse |
| halt_done | output | 1 | Termination-then-halt pulse |
| bus_error | output | 1 | Bus-error exception pulse |
| berr_deferred | output | 1 | Deferrable flag accompanying `bus_error` |
| retry | output | 1 | Retry pulse |
| stall | output | 1 | High while halt holds the master after `halt_done` or `retry` |

## Verification
On every clock, the checker confirms three things about the outputs:
- The result pulses are one-hot and last one clock.
- `berr_deferred` appears only together with `bus_error`.
- `stall` begins only together with a `halt_done` or `retry` pulse and is never high alongside `done` or `bus_error`.

Which result a given ordering of acknowledge, error and halt produces can only be shown by the directed scenarios. The same is true for the exact latency of each wait round and the release of `stall` after halt is negated. The scenarios cover the early, late and illegal orderings.

// File: rtl/term_pkg.sv
package term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AWAIT_N,
        ST_AWAIT_N2,
        ST_STALL
    } term_state_e;

    typedef enum logic [1:0] {
        RES_DONE,
        RES_HALT_DONE,
        RES_BERR,
        RES_RETRY
    } term_result_e;

    typedef struct packed {
        logic ack;
        logic berr;
        logic halt;
    } term_sample_t;

endpackage

// File: rtl/term_sync.sv
module term_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] dout_n
);
    // Two flops per bit; reset to the negated (high) level.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b1;
                stable_q <= 1'b1;
            end else begin
                meta_q   <= din_n[i];
                stable_q <= meta_q;
            end
        end
        assign dout_n[i] = stable_q;
    end
endmodule

// File: rtl/bus_state_ctr.sv
module bus_state_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    output logic [CNT_W-1:0] state_num,
    output logic             even_state
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_num <= '0;
        end else if (clear) begin
            state_num <= '0;
        end else if (enable) begin
            state_num <= state_num + 1'b1;
        end
    end

    assign even_state = ~state_num[0];
endmodule

// File: rtl/term_decode.sv
module term_decode
    import term_pkg::*;
(
    input  term_sample_t first_s,
    input  term_sample_t second_s,
    output term_result_e result
);
    logic ack_only_n;
    logic c_normal, c_halt, c_berr_early, c_berr_late, c_retry_early, c_retry_late;

    always_comb begin
        ack_only_n    = first_s.ack & ~first_s.berr & ~first_s.halt;
        c_normal      = ack_only_n & second_s.ack & ~second_s.berr;
        c_halt        = first_s.ack & ~first_s.berr & first_s.halt &
                        second_s.ack & ~second_s.berr & second_s.halt;
        c_berr_early  = first_s.berr & ~first_s.halt & second_s.berr & ~second_s.halt;
        c_berr_late   = ack_only_n & second_s.berr & ~second_s.halt;
        c_retry_early = first_s.berr & first_s.halt & second_s.berr & second_s.halt;
        c_retry_late  = ack_only_n & second_s.berr & second_s.halt;

        if (c_normal)                           result = RES_DONE;
        else if (c_halt)                        result = RES_HALT_DONE;
        else if (c_retry_early || c_retry_late) result = RES_RETRY;
        else if (c_berr_early || c_berr_late)   result = RES_BERR;
        else                                    result = RES_BERR; // R10 fallback
    end
endmodule

// File: rtl/bus_term_classifier.sv
module bus_term_classifier
    import term_pkg::*;
#(
    parameter int ACK_W = 2,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic [ACK_W-1:0] ack_n,
    input  logic             berr_n,
    input  logic             halt_n,
    input  logic             defer_en,
    output logic             done,
    output logic             halt_done,
    output logic             bus_error,
    output logic             berr_deferred,
    output logic             retry,
    output logic             stall
);
    localparam int SYNC_W = ACK_W + 2;

    term_state_e  state_q, state_d;
    term_sample_t live_s, first_q;
    term_result_e result;
    logic [SYNC_W-1:0] sync_n;
    logic [CNT_W-1:0]  state_num;
    logic              even_state;
    logic              classify_now;

    term_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  ({halt_n, berr_n, ack_n}),
        .dout_n (sync_n)
    );

    bus_state_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_q == ST_IDLE),
        .enable     ((state_q == ST_AWAIT_N) || (state_q == ST_AWAIT_N2)),
        .state_num  (state_num),
        .even_state (even_state)
    );

    always_comb begin
        live_s.ack  = ~&sync_n[ACK_W-1:0];
        live_s.berr = ~sync_n[ACK_W];
        live_s.halt = ~sync_n[ACK_W+1];
    end

    term_decode u_decode (
        .first_s  (first_q),
        .second_s (live_s),
        .result   (result)
    );

    assign classify_now = (state_q == ST_AWAIT_N2) && even_state;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cycle_start) state_d = ST_AWAIT_N;
            ST_AWAIT_N:  if (even_state && (live_s.ack || live_s.berr)) state_d = ST_AWAIT_N2;
            ST_AWAIT_N2: begin
                if (even_state) begin
                    if ((result == RES_HALT_DONE || result == RES_RETRY) && live_s.halt)
                        state_d = ST_STALL;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_STALL:    if (!live_s.halt) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and first-sample capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_AWAIT_N && even_state)
                first_q <= live_s;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done          <= 1'b0;
            halt_done     <= 1'b0;
            bus_error     <= 1'b0;
            berr_deferred <= 1'b0;
            retry         <= 1'b0;
            stall         <= 1'b0;
        end else begin
            done          <= classify_now && (result == RES_DONE);
            halt_done     <= classify_now && (result == RES_HALT_DONE);
            bus_error     <= classify_now && (result == RES_BERR);
            berr_deferred <= classify_now && (result == RES_BERR) && defer_en;
            retry         <= classify_now && (result == RES_RETRY);
            stall         <= (state_d == ST_STALL);
        end
    end
endmodule

// File: rtl/bus_term_checker.sv
module bus_term_checker (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic halt_done,
    input logic bus_error,
    input logic berr_deferred,
    input logic retry,
    input logic stall
);
    AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, halt_done, bus_error, retry}));                          // R12
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || halt_done || bus_error || retry) |=> !(done || halt_done || bus_error || retry)); // R12
    AST_DEFER_WITH_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        berr_deferred |-> bus_error);                                           // R11
    AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> (halt_done || retry));                                 // R9
    AST_STALL_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_done || retry) |-> stall);                                        // R9
    AST_NO_STALL_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done || bus_error) |-> !stall);                                        // R9
endmodule

bind bus_term_classifier bus_term_checker u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .halt_done     (halt_done),
    .bus_error     (bus_error),
    .berr_deferred (berr_deferred),
    .retry         (retry),
    .stall         (stall)
);

// File: tb/bus_term_classifier_tb.sv
module bus_term_classifier_tb;
    localparam int CLK_PERIOD = 10;

    // result codes: 1 done, 2 halt_done, 3 bus_error, 4 retry, 0 none
    localparam int R_NONE = 0, R_DONE = 1, R_HALT = 2, R_BERR = 3, R_RETRY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_start = 1'b0;
    logic [1:0] ack_n = 2'b11;
    logic       berr_n = 1'b1;
    logic       halt_n = 1'b1;
    logic       defer_en = 1'b0;
    logic done, halt_done, bus_error, berr_deferred, retry, stall;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_term_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n), .defer_en(defer_en),
        .done(done), .halt_done(halt_done), .bus_error(bus_error),
        .berr_deferred(berr_deferred), .retry(retry), .stall(stall)
    );

    task automatic check(input string req, input int actual, input int expected);
        tests_run++;
        if (actual != expected) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int result_code();
        if (done)      return R_DONE;
        if (halt_done) return R_HALT;
        if (bus_error) return R_BERR;
        if (retry)     return R_RETRY;
        return R_NONE;
    endfunction

    // pre_*: levels settled before start; late_*: levels applied right after the start edge.
    task automatic run_case(input string req,
                            input logic [1:0] pre_ack, input logic pre_berr, input logic pre_halt,
                            input logic [1:0] late_ack, input logic late_berr, input logic late_halt,
                            input logic dfr, input int exp_res, input int exp_lat);
        int lat = 0;
        int got = R_NONE;
        int got_dfr = 0;
        int got_stall = 0;
        @(negedge clk);
        ack_n = pre_ack; berr_n = pre_berr; halt_n = pre_halt; defer_en = dfr;
        repeat (3) @(negedge clk);
        cycle_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cycle_start = 1'b0;
        ack_n = late_ack; berr_n = late_berr; halt_n = late_halt;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (result_code() != R_NONE) begin
                got = result_code();
                got_dfr = berr_deferred;
                got_stall = stall;
                break;
            end
        end
        check({req, " result"}, got, exp_res);
        check({req, " latency"}, lat, exp_lat);
        check({req, " R11 deferred flag"}, got_dfr, (exp_res == R_BERR && dfr) ? 1 : 0);
        check({req, " R9 stall at result"}, got_stall, (exp_res == R_HALT || exp_res == R_RETRY) ? 1 : 0);
        @(negedge clk);
        check({req, " R12 single pulse"}, result_code(), R_NONE);
        if (exp_res == R_HALT || exp_res == R_RETRY) begin
            repeat (2) @(negedge clk);
            check({req, " R9 stall held"}, stall, 1);
            ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1;
            @(negedge clk);
            check({req, " R9 stall still high after release"}, stall, 1);
            repeat (3) @(negedge clk);
            check({req, " R9 stall released"}, stall, 0);
        end
        ack_n = 2'b11; berr_n = 1'b1; halt_n = 1'b1; defer_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset outputs",
              {29'd0, done, halt_done, bus_error} | {28'd0, berr_deferred, retry, stall, 1'b0}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R3 normal, both ack widths
        run_case("R3 normal 16b", 2'b10, 1, 1, 2'b10, 1, 1, 0, R_DONE, 3);
        run_case("R3 normal 32b late halt ignored", 2'b00, 1, 1, 2'b00, 1, 0, 0, R_DONE, 3);
        // R2 wait states: nothing asserted, ack arrives late
        run_case("R2 wait then normal", 2'b11, 1, 1, 2'b01, 1, 1, 0, R_DONE, 5);
        // R4 halt with ack, and halt earlier than ack (waits)
        run_case("R4 halt with ack", 2'b10, 1, 0, 2'b10, 1, 0, 0, R_HALT, 3);
        run_case("R4 R2 halt before ack", 2'b11, 1, 0, 2'b10, 1, 0, 0, R_HALT, 5);
        // R5 early bus error, with and without ack
        run_case("R5 berr no ack", 2'b11, 0, 1, 2'b11, 0, 1, 0, R_BERR, 3);
        run_case("R5 berr with ack deferred", 2'b00, 0, 1, 2'b00, 0, 1, 1, R_BERR, 3);
        // R6 late error
        run_case("R6 late berr", 2'b10, 1, 1, 2'b10, 0, 1, 1, R_BERR, 3);
        // R7 early retry
        run_case("R7 retry early", 2'b11, 0, 0, 2'b11, 0, 0, 0, R_RETRY, 3);
        run_case("R7 retry with ack", 2'b00, 0, 0, 2'b00, 0, 0, 0, R_RETRY, 3);
        // R8 late retry
        run_case("R8 late retry", 2'b10, 1, 1, 2'b10, 0, 0, 0, R_RETRY, 3);
        // R10 illegal orderings
        run_case("R10 halt dropped early", 2'b10, 1, 0, 2'b10, 1, 1, 0, R_BERR, 3);
        run_case("R10 halt after berr", 2'b11, 0, 1, 2'b11, 0, 0, 1, R_BERR, 3);
        run_case("R10 ack withdrawn", 2'b10, 1, 1, 2'b11, 1, 1, 0, R_BERR, 3);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule